// File: doc/BRIEF.md
# Routed Level-Sensitive Interrupt Controller

This block gathers nine external interrupt inputs and presents them to an upstream interrupt controller on three level-sensitive request wires. Each input first crosses a two-flop synchroniser and is then compared against its active level. Any cycle in which that level is seen sets a pending bit that stays latched until software acknowledges it.

Software chooses which request wire serves a source by setting the source's enable bit in that wire's control word. A request wire is high while any source that is both enabled on it and pending exists. Each of the three control words also reports the shared pending vector in its upper half. Writing ones there acknowledges the corresponding sources. A separate word sets each source's active level. Three sources have a level fixed by the board, which the word cannot change.

The register bus carries 32-bit words with a valid strobe, a write flag and a byte address. Read data is registered.

Top module: `irq_router`

## Requirements
- R1: After reset the stored polarity bits, all enable bits and all pending bits are 0, so `irq_out` is 3'b000.
- R2: The word at byte offset 0x0 sets polarity: bit n = 1 makes source n active-high and bit n = 0 makes it active-low. Configurable bits read back as written.
- R3: Sources 1 and 8 are always active-high and source 2 is always active-low. Writes to polarity bits 1, 2 and 8 are ignored, and those bits read as 1, 0 and 1.
- R4: The control word of request line k sits at byte offset 0x4 + 4*k (0x4, 0x8, 0xC). Its bits [8:0] are the per-source enables and read back as written.
- R5: A pending bit is set in every cycle in which the synchronised input equals its active level, and it stays set after the input goes inactive. Bits [24:16] of all three control words show the same pending vector, with bit 16+n belonging to source n.
- R6: Writing 1 to bit 16+n of any control word clears pending bit n. Writing 0 there leaves it unchanged. If source n is still active in the acknowledge cycle, the bit stays set.
- R7: `irq_out[k]` is high exactly while a source is both pending and enabled in control word k. A change on `src_in` can reach `irq_out` no earlier than the third rising clock edge after it.
- R8: Bits [15:9] and [31:25] of every word read as 0 and are not stored. Offsets other than 0x0, 0x4, 0x8 and 0xC read as 0 and ignore writes.
- R9: Read data appears on `bus_rdata` after the rising edge that samples the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | 9 | Asynchronous interrupt inputs |
| irq_out | output | 3 | Level-sensitive request lines |

## Verification
The acknowledge write and the set condition of the same pending bit can occur in one cycle. Set must win, so a source whose level is still active cannot be lost by an early acknowledge. The bench holds source 8 active while writing its acknowledge bit. It then requires request line 2 to stay high in the following cycle and the control word to read back with the pending bit still set. It also releases the source and acknowledges again, and expects the line to drop.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int N_SRC    = 9,
  parameter int N_OUT    = 3,
  parameter int AW       = 6,
  parameter int DW       = 32,
  parameter int PEND_LSB = 16,
  parameter logic [N_SRC-1:0] FIX_MASK  = 9'h106,
  parameter logic [N_SRC-1:0] FIX_LEVEL = 9'h102
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [N_SRC-1:0] src_in,
  output logic [N_OUT-1:0] irq_out
);

  localparam int STEP = 4;

  logic [N_SRC-1:0] sync1, sync2, pol_q, pol_eff, act, pend, clr;
  logic [N_SRC-1:0] en [N_OUT];
  logic [N_OUT-1:0] sel_ctl;
  logic             sel_pol, wr, rd;
  logic [DW-1:0]    rd_mux;
  logic             unused_wbits;

  assign wr      = bus_valid && bus_write;
  assign rd      = bus_valid && !bus_write;
  assign sel_pol = (bus_addr == '0);
  assign pol_eff = (pol_q & ~FIX_MASK) | (FIX_LEVEL & FIX_MASK);
  assign act     = ~(sync2 ^ pol_eff);
  assign clr     = (wr && |sel_ctl) ? bus_wdata[PEND_LSB +: N_SRC] : '0;
  assign unused_wbits = ^{bus_wdata[DW-1:PEND_LSB+N_SRC], bus_wdata[PEND_LSB-1:N_SRC]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      pol_q <= '0;
      pend  <= '0;
    end else begin
      sync1 <= src_in;
      sync2 <= sync1;
      if (wr && sel_pol) pol_q <= bus_wdata[N_SRC-1:0] & ~FIX_MASK;
      pend <= (pend & ~clr) | act;
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_line
    assign sel_ctl[k] = (bus_addr == AW'((k + 1) * STEP));
    always_ff @(posedge clk) begin
      if (!rst_n)               en[k] <= '0;
      else if (wr && sel_ctl[k]) en[k] <= bus_wdata[N_SRC-1:0];
    end
    assign irq_out[k] = |(en[k] & pend);
  end

  always_comb begin
    rd_mux = '0;
    if (sel_pol) rd_mux[N_SRC-1:0] = pol_eff;
    for (int k = 0; k < N_OUT; k++) begin
      if (sel_ctl[k]) begin
        rd_mux[N_SRC-1:0]           = en[k];
        rd_mux[PEND_LSB +: N_SRC]   = pend;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end

  // R1: nothing pending in the first cycle out of reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pend == '0 && irq_out == '0));

  // R5: an active level is latched on the next edge
  a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
    (act != '0) |=> ((pend & $past(act)) == $past(act)));

  // R5: a pending bit falls only through an acknowledge
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~pend & $past(pend) & ~$past(clr)) == '0));

  // R6: acknowledge of an inactive source clears it
  a_r6_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((pend & $past(clr & ~act)) == '0));

  // R7: no request without a pending source
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (irq_out == '0));

  // R8: reserved read bits stay zero
  a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[PEND_LSB-1:N_SRC] == '0) && (bus_rdata[DW-1:PEND_LSB+N_SRC] == '0));

endmodule

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [8:0]  src_in = 9'h0FD;
  logic [2:0]  irq_out;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  irq_router i_irq_router (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_in(src_in), .irq_out(irq_out));

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_valid = 0;
  endtask

  task automatic chk_irq(input logic [2:0] e, input string t);
    n_chk++;
    if (irq_out !== e) begin
      n_fail++;
      $display("FAIL %s irq_out actual=%b expected=%b", t, irq_out, e);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      if (bus_valid && !bus_write) begin
        @(negedge clk);
        n_chk++;
        if (bus_rdata !== exp_q[0]) begin
          n_fail++;
          $display("FAIL %s rdata actual=%h expected=%h", tag_q[0], bus_rdata, exp_q[0]);
        end
        void'(exp_q.pop_front()); void'(tag_q.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    wait_n(3);
    chk_irq(3'b000, "R1 during reset");
    rst_n = 1;
    rd(6'h0, 32'h0000_0102, "R1 R3 polarity after reset");
    // init: disable all, ack all
    wr(6'h4, 32'h01FF_0000); wr(6'h8, 32'h01FF_0000); wr(6'hC, 32'h01FF_0000);
    rd(6'h4, 32'h0000_0000, "R1 control word after init");
    chk_irq(3'b000, "R1 outputs idle");
    // all configurable sources active-high
    wr(6'h0, 32'hFFFF_FFFF);
    src_in = 9'h004;
    wait_n(4);
    rd(6'h0, 32'h0000_01FB, "R2 R3 R8 polarity readback");
    wr(6'h4, 32'h01FF_0000);
    rd(6'h8, 32'h0000_0000, "R6 ack clears all");
    wr(6'h4, 32'hFE00_FE03);
    rd(6'h4, 32'h0000_0003, "R4 R8 enable readback");
    wr(6'h8, 32'h0000_0004);
    wr(6'hC, 32'h0000_0100);
    chk_irq(3'b000, "R7 enabled but none pending");
    // source 0 pulse: latency then latch
    @(negedge clk); src_in = 9'h005;
    wait_n(2); chk_irq(3'b000, "R7 two edges after input");
    wait_n(1); chk_irq(3'b001, "R7 third edge after input");
    src_in = 9'h004;
    rd(6'hC, 32'h0001_0100, "R5 pending seen in other line word");
    wait_n(4); chk_irq(3'b001, "R5 pending held after release");
    wr(6'h4, 32'h0000_0003);
    chk_irq(3'b001, "R6 writing zero keeps pending");
    wr(6'h4, 32'h0001_0003);
    chk_irq(3'b000, "R6 ack clears line 0");
    // collision: ack while source 8 still active
    @(negedge clk); src_in = 9'h104;
    wait_n(3); chk_irq(3'b100, "R3 R7 source 8 active-high");
    wr(6'hC, 32'h0100_0100);
    chk_irq(3'b100, "R6 ack while active keeps line");
    rd(6'hC, 32'h0100_0100, "R6 pending re-set after ack");
    src_in = 9'h004;
    wait_n(4);
    wr(6'hC, 32'h0100_0100);
    chk_irq(3'b000, "R6 ack after release");
    // source 2 fixed active-low even though bit written 1
    @(negedge clk); src_in = 9'h000;
    wait_n(3); chk_irq(3'b010, "R3 source 2 active-low");
    src_in = 9'h004;
    wait_n(4);
    wr(6'h8, 32'h0004_0004);
    chk_irq(3'b000, "R6 source 2 acked");
    // polarity back to low: source 0 idle at 0 is now active
    wr(6'h0, 32'h0000_0000);
    wait_n(2); chk_irq(3'b001, "R2 active-low source 0 asserts");
    rd(6'h0, 32'h0000_0102, "R2 polarity cleared readback");
    src_in = 9'h0FD;
    wait_n(4);
    wr(6'h4, 32'h01FF_0003);
    chk_irq(3'b000, "R2 inactive after level flip");
    rd(6'h4, 32'h0000_0003, "R5 no pending after ack");
    // unmapped offset
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h4, 32'h0000_0003, "R8 unmapped write ignored");
    rd(6'h10, 32'h0000_0000, "R8 unmapped reads zero");
    rd(6'h0, 32'h0000_0102, "R9 read for hold check");
    wait_n(3);
    n_chk++;
    if (bus_rdata !== 32'h0000_0102) begin
      n_fail++;
      $display("FAIL R9 rdata hold actual=%h expected=%h", bus_rdata, 32'h0000_0102);
    end
    wait_n(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule